// File: doc/BRIEF.md
# Dual-context page translation buffer

This block is the first-level address translation store for an 18-bit word-addressed virtual space. It keeps two direct-mapped tables, one for executive-mode references and one for user-mode references. Each table has one entry per 512-word page. A lookup presents an address, a read or write kind, and a flag that says whether the reference is in the current or the previous context. One cycle later the block answers with one of three results: a physical address, an accumulator hit, or a refill request. A refill request tells the page-table walker outside the block to resolve the reference and write the entry back through the fill port.

Entries are filled one at a time. The walker can invalidate a single page in both tables at once, or a pair of pages when the double-size page mode is in use. It can wipe both tables completely, which it does whenever a new executive or user base register is loaded. When paging is turned off, every lookup maps to itself and is always writeable.

Top module: `dual_ctx_xlate`

## Requirements
- R1: After reset every output is 0, and every entry of both tables is invalid, so the first mapped read of any page returns a refill.
- R2: A response (`rsp_valid` = 1) appears exactly one clock after each cycle with `lk_req` = 1, and at no other time.
- R3: On a mapped hit, `rsp_paddr` is the stored 11-bit page number in bits 19:9 with lookup address bits 8:0 in bits 8:0. A read of a read-only entry is a hit.
- R4: A mapped read whose entry is invalid gives `rsp_refill` = 1 with `rsp_paddr` = 0.
- R5: A mapped write gives `rsp_refill` = 1 unless the entry is valid and modifiable. A write to a read-write entry is a hit as in R3.
- R6: With `paging_on` = 0, a lookup at address 16 or above returns `rsp_paddr` equal to the zero-extended address, never with a refill, whatever the tables hold.
- R7: A lookup at an address below 16 returns `rsp_ac` = 1, `rsp_refill` = 0 and `rsp_paddr` equal to the address, whether paging is on or off.
- R8: The table in use is reported on `rsp_user` (1 = user table) and is chosen as follows. With `user_mode` = 1 the user table is used. With `user_mode` = 0 the executive table is used, except when `lk_prev` = 1 and `user_io` = 1, which selects the user table.
- R9: A fill writes the table named by `fill_user` at page `fill_vpn`. With `fill_valid` = 0 the entry becomes invalid even if `fill_mod` = 1. With `fill_valid` = 1 the entry is read-only when `fill_mod` = 0 and read-write when `fill_mod` = 1.
- R10: `clr_page` invalidates page `clr_vpn` in both tables and leaves every other page untouched.
- R11: With `double_page` = 1, `clr_page` invalidates both the even and the odd page of the pair containing `clr_vpn`, in both tables.
- R12: `clr_all` invalidates every entry of both tables. A lookup in the same cycle already sees the cleared tables.
- R13: A fill in the same cycle as a lookup of the same page in the selected table takes effect for that lookup. Within one cycle the priority is `clr_all` over `clr_page` over fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 18 | Virtual word address |
| lk_write | input | 1 | 1 = write reference, 0 = read |
| lk_prev | input | 1 | 1 = previous context, 0 = current |
| user_mode | input | 1 | Processor is in user mode |
| user_io | input | 1 | Previous context of executive mode is the user space |
| paging_on | input | 1 | 0 = identity mapping |
| double_page | input | 1 | Page clears act on even/odd pairs |
| fill_en | input | 1 | Write one entry |
| fill_user | input | 1 | Fill target: 1 = user table, 0 = executive table |
| fill_vpn | input | 9 | Page number to fill |
| fill_valid | input | 1 | Entry valid bit |
| fill_mod | input | 1 | Entry modifiable bit |
| fill_ppn | input | 11 | Physical page number |
| clr_page | input | 1 | Invalidate one page (or pair) in both tables |
| clr_vpn | input | 9 | Page to invalidate |
| clr_all | input | 1 | Invalidate both tables (base register load) |
| rsp_valid | output | 1 | Response present |
| rsp_ac | output | 1 | Address was an accumulator reference |
| rsp_refill | output | 1 | Entry missing or not writeable; walker must refill |
| rsp_user | output | 1 | Table used for this response |
| rsp_paddr | output | 20 | Physical address |

## Verification
A flag bit left set after a page clear or a clear-all shows up as a stale physical address where a refill was due. The bench sees it one cycle after the next lookup of that page. A modifiable bit that was not cleared lets a write through to a read-only page. A context-select fault shows at once as a wrong `rsp_user` value and as a physical number from the wrong table. The bench keeps its own copy of both tables, so each of these shows up at the first lookup that touches the damaged entry. Pages are drawn from a small pool, so hits and same-cycle collisions between fills and clears happen often.

// File: rtl/dcx_pkg.sv
package dcx_pkg;
  typedef enum logic {TBL_EXEC = 1'b0, TBL_USER = 1'b1} tbl_sel_e;

  // A reference needs the walker when the entry is absent, or on a write
  // when the entry does not allow modification.
  function automatic logic needs_refill(input logic vld, input logic mdf,
                                        input logic is_wr);
    return is_wr ? !(vld && mdf) : !vld;
  endfunction
endpackage

// File: rtl/dcx_ctx_sel.sv
module dcx_ctx_sel
  import dcx_pkg::*;
(
  input  logic     user_mode,
  input  logic     user_io,
  input  logic     prev,
  output tbl_sel_e sel
);
  always_comb begin
    if (user_mode)            sel = TBL_USER;
    else if (prev && user_io) sel = TBL_USER;
    else                      sel = TBL_EXEC;
  end
endmodule

// File: rtl/dcx_clr_dec.sv
module dcx_clr_dec #(
  parameter int VPN_W = 9
) (
  input  logic             en,
  input  logic             pair,
  input  logic [VPN_W-1:0] vpn,
  output logic             a_en,
  output logic [VPN_W-1:0] a_idx,
  output logic             b_en,
  output logic [VPN_W-1:0] b_idx
);
  always_comb begin
    a_en  = en;
    a_idx = pair ? {vpn[VPN_W-1:1], 1'b0} : vpn;
    b_en  = en && pair;
    b_idx = {vpn[VPN_W-1:1], 1'b1};
  end
endmodule

// File: rtl/dcx_table.sv
module dcx_table #(
  parameter int VPN_W = 9,
  parameter int PPN_W = 11,
  localparam int DEPTH = 1 << VPN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_all,
  input  logic             clr_a_en,
  input  logic [VPN_W-1:0] clr_a_idx,
  input  logic             clr_b_en,
  input  logic [VPN_W-1:0] clr_b_idx,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic             wr_mod,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             rd_en,
  input  logic [VPN_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_mod,
  output logic [PPN_W-1:0] rd_ppn
);
  // Flags live in flops so a whole table can be wiped in one edge;
  // page numbers live in a plain array suited to block RAM.
  logic [DEPTH-1:0] valid_q, mod_q;
  logic [PPN_W-1:0] ppn_mem [DEPTH];
  logic             wr_hit, v_next, m_next;
  logic             m_store;

  assign wr_hit  = wr_en && (wr_idx == rd_idx);
  assign m_store = wr_valid && wr_mod;

  always_comb begin
    v_next = valid_q[rd_idx];
    m_next = mod_q[rd_idx];
    if (wr_hit) begin
      v_next = wr_valid;
      m_next = m_store;
    end
    if ((clr_a_en && clr_a_idx == rd_idx) || (clr_b_en && clr_b_idx == rd_idx)
        || clr_all) begin
      v_next = 1'b0;
      m_next = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      mod_q    <= '0;
      rd_valid <= 1'b0;
      rd_mod   <= 1'b0;
    end else begin
      if (clr_all) begin
        valid_q <= '0;
        mod_q   <= '0;
      end else begin
        if (wr_en) begin
          valid_q[wr_idx] <= wr_valid;
          mod_q[wr_idx]   <= m_store;
        end
        if (clr_a_en) begin
          valid_q[clr_a_idx] <= 1'b0;
          mod_q[clr_a_idx]   <= 1'b0;
        end
        if (clr_b_en) begin
          valid_q[clr_b_idx] <= 1'b0;
          mod_q[clr_b_idx]   <= 1'b0;
        end
      end
      if (rd_en) begin
        rd_valid <= v_next;
        rd_mod   <= m_next;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) ppn_mem[wr_idx] <= wr_ppn;
    if (rd_en) rd_ppn <= wr_hit ? wr_ppn : ppn_mem[rd_idx];
  end
endmodule

// File: rtl/dual_ctx_xlate.sv
module dual_ctx_xlate
  import dcx_pkg::*;
#(
  parameter int VA_W   = 18,
  parameter int OFS_W  = 9,
  parameter int PPN_W  = 11,
  parameter int AC_TOP = 16,
  localparam int VPN_W = VA_W - OFS_W,
  localparam int PA_W  = PPN_W + OFS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_req,
  input  logic [VA_W-1:0]  lk_addr,
  input  logic             lk_write,
  input  logic             lk_prev,
  input  logic             user_mode,
  input  logic             user_io,
  input  logic             paging_on,
  input  logic             double_page,
  input  logic             fill_en,
  input  logic             fill_user,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic             fill_valid,
  input  logic             fill_mod,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             clr_page,
  input  logic [VPN_W-1:0] clr_vpn,
  input  logic             clr_all,
  output logic             rsp_valid,
  output logic             rsp_ac,
  output logic             rsp_refill,
  output logic             rsp_user,
  output logic [PA_W-1:0]  rsp_paddr
);
  localparam logic [VA_W-1:0] AC_LIM = VA_W'(AC_TOP);

  tbl_sel_e         sel_now;
  logic             ca_en, cb_en;
  logic [VPN_W-1:0] ca_idx, cb_idx;
  logic             is_ac;
  logic [VPN_W-1:0] lk_vpn;

  logic             s_req, s_ac, s_map, s_wr, s_user;
  logic [VA_W-1:0]  s_addr;

  logic             t_v [2];
  logic             t_m [2];
  logic [PPN_W-1:0] t_p [2];
  logic             sel_v, sel_m, miss;
  logic [PPN_W-1:0] sel_p;

  assign is_ac  = lk_addr < AC_LIM;
  assign lk_vpn = lk_addr[VA_W-1:OFS_W];

  dcx_ctx_sel i_ctx (
    .user_mode(user_mode), .user_io(user_io), .prev(lk_prev), .sel(sel_now)
  );

  dcx_clr_dec #(.VPN_W(VPN_W)) i_clr (
    .en(clr_page), .pair(double_page), .vpn(clr_vpn),
    .a_en(ca_en), .a_idx(ca_idx), .b_en(cb_en), .b_idx(cb_idx)
  );

  for (genvar g = 0; g < 2; g++) begin : g_tbl
    localparam logic TBL_BIT = (g == 1);
    dcx_table #(.VPN_W(VPN_W), .PPN_W(PPN_W)) i_tbl (
      .clk(clk), .rst(rst), .clr_all(clr_all),
      .clr_a_en(ca_en), .clr_a_idx(ca_idx),
      .clr_b_en(cb_en), .clr_b_idx(cb_idx),
      .wr_en(fill_en && (fill_user == TBL_BIT)), .wr_idx(fill_vpn),
      .wr_valid(fill_valid), .wr_mod(fill_mod), .wr_ppn(fill_ppn),
      .rd_en(lk_req), .rd_idx(lk_vpn),
      .rd_valid(t_v[g]), .rd_mod(t_m[g]), .rd_ppn(t_p[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_req  <= 1'b0;
      s_ac   <= 1'b0;
      s_map  <= 1'b0;
      s_wr   <= 1'b0;
      s_user <= 1'b0;
      s_addr <= '0;
    end else begin
      s_req  <= lk_req;
      s_ac   <= lk_req && is_ac;
      s_map  <= lk_req && paging_on && !is_ac;
      s_wr   <= lk_write;
      s_user <= (sel_now == TBL_USER);
      s_addr <= lk_addr;
    end
  end

  assign sel_v = s_user ? t_v[1] : t_v[0];
  assign sel_m = s_user ? t_m[1] : t_m[0];
  assign sel_p = s_user ? t_p[1] : t_p[0];
  assign miss  = needs_refill(sel_v, sel_m, s_wr);

  always_comb begin
    rsp_valid  = s_req;
    rsp_ac     = s_ac;
    rsp_user   = s_req && s_user;
    rsp_refill = s_map && miss;
    if (!s_req)     rsp_paddr = '0;
    else if (!s_map) rsp_paddr = PA_W'(s_addr);
    else if (miss)  rsp_paddr = '0;
    else            rsp_paddr = {sel_p, s_addr[OFS_W-1:0]};
  end
endmodule

// File: rtl/dcx_xlate_chk.sv
module dcx_xlate_chk #(
  parameter int VA_W   = 18,
  parameter int OFS_W  = 9,
  parameter int PPN_W  = 11,
  parameter int AC_TOP = 16,
  localparam int VPN_W = VA_W - OFS_W,
  localparam int PA_W  = PPN_W + OFS_W
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_req,
  input logic [VA_W-1:0]  lk_addr,
  input logic             lk_write,
  input logic             lk_prev,
  input logic             user_mode,
  input logic             user_io,
  input logic             paging_on,
  input logic             double_page,
  input logic             fill_en,
  input logic             fill_user,
  input logic [VPN_W-1:0] fill_vpn,
  input logic             fill_valid,
  input logic             fill_mod,
  input logic [PPN_W-1:0] fill_ppn,
  input logic             clr_page,
  input logic [VPN_W-1:0] clr_vpn,
  input logic             clr_all,
  input logic             rsp_valid,
  input logic             rsp_ac,
  input logic             rsp_refill,
  input logic             rsp_user,
  input logic [PA_W-1:0]  rsp_paddr
);
  localparam logic [VA_W-1:0] AC_LIM = VA_W'(AC_TOP);
  logic armed;
  logic ctx_user;

  always_ff @(posedge clk) armed <= !rst;
  assign ctx_user = user_mode || (lk_prev && user_io);

  p_latency_r2: assert property (@(posedge clk) disable iff (rst || !armed)
    1'b1 |-> (rsp_valid == $past(lk_req)));

  p_acc_bypass_r7: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(lk_req && lk_addr < AC_LIM) |->
      (rsp_ac && !rsp_refill && rsp_paddr == PA_W'($past(lk_addr))));

  p_identity_r6: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(lk_req && !paging_on && lk_addr >= AC_LIM) |->
      (!rsp_refill && rsp_paddr == PA_W'($past(lk_addr))));

  p_refill_zero_r4: assert property (@(posedge clk) disable iff (rst || !armed)
    rsp_refill |-> (rsp_paddr == '0 && !rsp_ac));

  p_user_ctx_r8: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(lk_req) |-> (rsp_user == $past(ctx_user)));

  p_wipe_r12: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(lk_req && paging_on && clr_all && lk_addr >= AC_LIM) |-> rsp_refill);

  p_fill_wins_r13: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(lk_req && paging_on && lk_addr >= AC_LIM && fill_en && fill_valid &&
          fill_mod && !clr_all && !clr_page && fill_user == ctx_user &&
          fill_vpn == lk_addr[VA_W-1:OFS_W]) |->
      (!rsp_refill && rsp_paddr[PA_W-1:OFS_W] == $past(fill_ppn)));
endmodule

bind dual_ctx_xlate dcx_xlate_chk #(
  .VA_W(VA_W), .OFS_W(OFS_W), .PPN_W(PPN_W), .AC_TOP(AC_TOP)
) i_chk (.*);

// File: tb/test_dual_ctx_xlate.sv
`timescale 1ns/1ps
module test_dual_ctx_xlate;
  localparam int NPG = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_req = 0, lk_write = 0, lk_prev = 0;
  logic [17:0] lk_addr = '0;
  logic        user_mode = 0, user_io = 0, paging_on = 0, double_page = 0;
  logic        fill_en = 0, fill_user = 0, fill_valid = 0, fill_mod = 0;
  logic [8:0]  fill_vpn = '0, clr_vpn = '0;
  logic [10:0] fill_ppn = '0;
  logic        clr_page = 0, clr_all = 0;
  logic        rsp_valid, rsp_ac, rsp_refill, rsp_user;
  logic [19:0] rsp_paddr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic        m_v [2][NPG];
  logic        m_m [2][NPG];
  logic [10:0] m_p [2][NPG];

  always #2 clk = ~clk;

  dual_ctx_xlate i_dual_ctx_xlate (.*);

  task automatic chk(input string tag, input string fld,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, fld, act, exp);
    end
  endtask

  function automatic logic want_user(input logic um, input logic pv, input logic uio);
    return um || (pv && uio);
  endfunction

  task automatic model_clear_all();
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < NPG; i++) begin
        m_v[t][i] = 1'b0;
        m_m[t][i] = 1'b0;
      end
  endtask

  // Apply the currently staged inputs for one cycle and check the response.
  task automatic cycle(input string tag);
    logic        e_v, e_ac, e_rf, e_u;
    logic [19:0] e_pa;
    logic        sel;
    logic [8:0]  vpn;
    // model update in the priority order of R13
    if (fill_en) begin
      m_v[fill_user][fill_vpn] = fill_valid;
      m_m[fill_user][fill_vpn] = fill_valid && fill_mod;
      m_p[fill_user][fill_vpn] = fill_ppn;
    end
    if (clr_page) begin
      for (int t = 0; t < 2; t++) begin
        if (double_page) begin
          m_v[t][{clr_vpn[8:1], 1'b0}] = 0; m_m[t][{clr_vpn[8:1], 1'b0}] = 0;
          m_v[t][{clr_vpn[8:1], 1'b1}] = 0; m_m[t][{clr_vpn[8:1], 1'b1}] = 0;
        end else begin
          m_v[t][clr_vpn] = 0; m_m[t][clr_vpn] = 0;
        end
      end
    end
    if (clr_all) model_clear_all();
    sel  = want_user(user_mode, lk_prev, user_io);
    vpn  = lk_addr[17:9];
    e_v  = lk_req;
    e_u  = lk_req && sel;
    e_ac = lk_req && (lk_addr < 18'd16);
    e_rf = 1'b0;
    e_pa = '0;
    if (lk_req) begin
      if (e_ac || !paging_on) e_pa = {2'b00, lk_addr};
      else begin
        e_rf = lk_write ? !(m_v[sel][vpn] && m_m[sel][vpn]) : !m_v[sel][vpn];
        e_pa = e_rf ? 20'h0 : {m_p[sel][vpn], lk_addr[8:0]};
      end
    end
    @(posedge clk);
    #1;
    chk(tag, "valid",  32'(rsp_valid),  32'(e_v));
    chk(tag, "ac",     32'(rsp_ac),     32'(e_ac));
    chk(tag, "refill", 32'(rsp_refill), 32'(e_rf));
    chk(tag, "user",   32'(rsp_user),   32'(e_u));
    chk(tag, "paddr",  32'(rsp_paddr),  32'(e_pa));
    @(negedge clk);
    lk_req = 0; fill_en = 0; clr_page = 0; clr_all = 0;
  endtask

  task automatic look(input logic [17:0] a, input logic wr, input logic pv,
                      input string tag);
    lk_req = 1; lk_addr = a; lk_write = wr; lk_prev = pv;
    cycle(tag);
  endtask

  task automatic fill(input logic u, input logic [8:0] vpn, input logic v,
                      input logic m, input logic [10:0] ppn);
    fill_en = 1; fill_user = u; fill_vpn = vpn;
    fill_valid = v; fill_mod = m; fill_ppn = ppn;
    cycle("R9 fill");
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_clear_all();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset", "valid",  32'(rsp_valid),  0);
    chk("R1 reset", "refill", 32'(rsp_refill), 0);
    chk("R1 reset", "paddr",  32'(rsp_paddr),  0);
    @(negedge clk);
    rst = 0;
    paging_on = 1;
    cycle("R2 idle");
    look({9'd40, 9'd3}, 0, 0, "R1 empty exec");
    user_mode = 1;
    look({9'd40, 9'd3}, 0, 0, "R1 empty user");
    user_mode = 0;

    // R3 / R5 read-only then read-write
    fill(0, 9'd5, 1, 0, 11'h123);
    look({9'd5, 9'h1AB}, 0, 0, "R3 read-only read hit");
    look({9'd5, 9'h1AB}, 1, 0, "R5 write to read-only");
    fill(1, 9'd5, 1, 1, 11'h2AA);
    user_mode = 1;
    look({9'd5, 9'h007}, 1, 0, "R5 write read-write");
    look({9'd5, 9'h007}, 0, 1, "R8 user prev");
    user_mode = 0; user_io = 1;
    look({9'd5, 9'h010}, 0, 1, "R8 exec prev user_io");
    look({9'd5, 9'h010}, 0, 0, "R8 exec current");
    user_io = 0;
    look({9'd5, 9'h010}, 0, 1, "R8 exec prev no user_io");

    // R9 invalid encoding, R4 refill
    fill(0, 9'd6, 0, 1, 11'h055);
    look({9'd6, 9'h000}, 0, 0, "R4 R9 invalid entry");

    // R6 identity and R7 accumulators
    paging_on = 0;
    look(18'h2F0F1, 1, 0, "R6 identity write");
    look(18'd9, 0, 0, "R7 ac paging off");
    paging_on = 1;
    look(18'd15, 1, 0, "R7 ac paging on");
    look(18'd16, 0, 0, "R7 first mapped word");

    // R13 fill and lookup together
    fill_en = 1; fill_user = 0; fill_vpn = 9'd77; fill_valid = 1; fill_mod = 1;
    fill_ppn = 11'h7F0;
    lk_req = 1; lk_addr = {9'd77, 9'h055}; lk_write = 1; lk_prev = 0;
    cycle("R13 fill wins");

    // R10 single clear both tables
    fill(0, 9'd8, 1, 1, 11'h011);
    fill(0, 9'd9, 1, 1, 11'h012);
    fill(0, 9'd10, 1, 1, 11'h013);
    clr_page = 1; clr_vpn = 9'd5; double_page = 0;
    cycle("R10 clear");
    look({9'd5, 9'h0}, 0, 0, "R10 exec cleared");
    user_mode = 1;
    look({9'd5, 9'h0}, 0, 0, "R10 user cleared");
    user_mode = 0;
    look({9'd77, 9'h0}, 0, 0, "R10 neighbour kept");

    // R11 pair clear
    clr_page = 1; clr_vpn = 9'd9; double_page = 1;
    cycle("R11 pair clear");
    double_page = 0;
    look({9'd8, 9'h1}, 0, 0, "R11 even cleared");
    look({9'd9, 9'h1}, 0, 0, "R11 odd cleared");
    look({9'd10, 9'h1}, 0, 0, "R11 next pair kept");

    // R12 wipe with concurrent lookup
    clr_all = 1;
    lk_req = 1; lk_addr = {9'd10, 9'h2}; lk_write = 0; lk_prev = 0;
    cycle("R12 wipe same cycle");
    look({9'd77, 9'h2}, 0, 0, "R12 wiped");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [8:0] rv;
      rv = 9'(($urandom % 16) + 9'h100 * ($urandom % 2));
      lk_req    = ($urandom % 4) != 0;
      lk_addr   = ($urandom % 25 == 0) ? 18'($urandom % 16)
                                       : {rv, 9'($urandom)};
      lk_write  = 1'($urandom);
      lk_prev   = 1'($urandom);
      user_mode = 1'($urandom);
      user_io   = 1'($urandom);
      paging_on = ($urandom % 10) != 0;
      double_page = 1'($urandom);
      fill_en   = ($urandom % 3) == 0;
      fill_user = 1'($urandom);
      fill_vpn  = 9'(($urandom % 16) + 9'h100 * ($urandom % 2));
      fill_valid = ($urandom % 5) != 0;
      fill_mod  = 1'($urandom);
      fill_ppn  = 11'($urandom);
      clr_page  = ($urandom % 20) == 0;
      clr_vpn   = 9'(($urandom % 16) + 9'h100 * ($urandom % 2));
      clr_all   = ($urandom % 200) == 0;
      cycle("R3 R5 R8 R13 random");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule